// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host side of one channel of a serial controller. The host sees only two byte-wide ports. One is the control port, which reaches every internal register by indirect addressing. The other is the data port, which reaches the transmit and receive buffers in a single access. Behind the ports are 16 write registers and 9 readable registers. The serial engines are outside the block. Their status and receive data come in on plain inputs, and register writes and buffer events go out as one-cycle pulses.

The port has two states.

- **IDLE:** a control-port write is a write to register 0. Its low three bits, plus 8 when its command field (bits 5:3) equals `001`, give the register pointer. The transition *select* moves the port to **ARMED** when that pointer is nonzero. When the pointer is zero the port stays in IDLE.
- **ARMED:** the next control-port read or write reaches the selected register. The transition *complete* then clears the pointer and returns the port to IDLE.

A control-port access in IDLE reaches register 0 directly. Data-port accesses never change the state or the pointer.

Top module: `regport_top`

## Requirements
- R1: After reset the port is IDLE with pointer 0, all stored write registers are 0x00, and no output pulse is active.
- R2: In IDLE, a control-port write is a register-0 write (pulse with index 0). It sets the pointer to bits 2:0 plus 8 when bits 5:3 equal `001`.
- R3: In ARMED, a control-port write stores the byte in the selected write register and pulses `reg_wr_en` with that index and byte one cycle later.
- R4: In ARMED, a control-port read returns the selected read register in the same cycle.
- R5: After any ARMED control-port access, the pointer returns to 0, so the next control-port read returns read register 0.
- R6: Read register 0 has bit 0 = `rx_avail`, bit 2 = `tx_empty`, and all other bits 0.
- R7: A data-port write pulses `tx_load` and a register write with index 8 carrying the byte, and leaves the state and pointer unchanged.
- R8: A data-port read, or a control-port read of register 8, returns `rx_byte` and pulses `rx_pop` one cycle later.
- R9: Writing 0x38 to register 0 pulses `ius_clr` one cycle later, and the pointer stays 0.
- R10: Reading an unimplemented read register number (4, 5, 6, 7, 9, 11, 14) returns 0x00.
- R11: Read registers 2, 12, 13 and 15 return the stored write registers of the same number. Read registers 1, 3 and 10 return `stat_a`, `stat_b` and `stat_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ctrl | input | 1 | 1 = control port, 0 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during a read strobe, 0 otherwise |
| rx_avail | input | 1 | Receive buffer holds a byte |
| tx_empty | input | 1 | Transmit buffer can accept a byte |
| rx_byte | input | 8 | Receive buffer contents |
| stat_a | input | 8 | Special receive condition status |
| stat_b | input | 8 | Interrupt pending status |
| stat_c | input | 8 | Miscellaneous status |
| reg_wr_en | output | 1 | Pulse: a register was written |
| reg_wr_idx | output | 4 | Index of the written register |
| reg_wr_data | output | 8 | Byte written |
| tx_load | output | 1 | Pulse: transmit buffer written |
| rx_pop | output | 1 | Pulse: receive buffer read |
| ius_clr | output | 1 | Pulse: reset highest interrupt under service |

## Verification
Two kinds of wrong internal state show up at the ports. A pointer left over from an earlier access, or a state stuck in ARMED, sends the very next control-port read to the wrong register, so `bus_rdata` differs in the same cycle as that read. A pointer that was decoded wrongly sends a write to the wrong register. That shows on `reg_wr_idx` one cycle later, and again on the next readback of registers 2, 12, 13 or 15. The stimulus therefore always follows a pointer load with an access, and then follows that with a plain read of register 0.

// File: rtl/regport_pkg.sv
package regport_pkg;
    typedef enum logic {PS_IDLE, PS_ARMED} port_state_t;
    localparam int          DW       = 8;
    localparam int          REG_CNT  = 16;
    localparam int          PTR_W    = $clog2(REG_CNT);
    localparam logic [2:0]  CMD_HIGH = 3'b001;
    localparam logic [7:0]  IUS_CMD  = 8'h38;
    localparam logic [PTR_W-1:0] BUF_IDX = PTR_W'(REG_CNT / 2);
endpackage

// File: rtl/regport_ptr_fsm.sv
module regport_ptr_fsm
    import regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_rd,
    input  logic [DW-1:0]    wdata,
    output logic [PTR_W-1:0] ptr,
    output logic             armed
);
    port_state_t      state_q, state_n;
    logic [PTR_W-1:0] ptr_q, ptr_n, sel_ptr;

    always_comb begin
        sel_ptr = PTR_W'(wdata[2:0]);
        if (wdata[5:3] == CMD_HIGH) sel_ptr = sel_ptr + BUF_IDX;
    end

    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        unique case (state_q)
            PS_IDLE: if (ctrl_wr) begin          // select
                ptr_n   = sel_ptr;
                state_n = (sel_ptr != '0) ? PS_ARMED : PS_IDLE;
            end
            PS_ARMED: if (ctrl_wr || ctrl_rd) begin  // complete
                ptr_n   = '0;
                state_n = PS_IDLE;
            end
            default: begin
                ptr_n   = '0;
                state_n = PS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
        end
    end

    always_comb begin
        armed = (state_q == PS_ARMED);
        ptr   = ptr_q;
    end

    p_complete_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (ctrl_wr || ctrl_rd)) |=> (!armed && ptr == '0));
    p_armed_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (ptr != '0));
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (ptr == '0));
endmodule

// File: rtl/regport_wbank.sv
module regport_wbank
    import regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    regs [REG_CNT]
);
    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                          q <= '0;
            else if (we && idx == PTR_W'(g))     q <= wdata;
        end
        assign regs[g] = q;
    end
endmodule

// File: rtl/regport_rmux.sv
module regport_rmux
    import regport_pkg::*;
(
    input  logic [PTR_W-1:0] idx,
    input  logic             rx_avail,
    input  logic             tx_empty,
    input  logic [DW-1:0]    rx_byte,
    input  logic [DW-1:0]    stat_a,
    input  logic [DW-1:0]    stat_b,
    input  logic [DW-1:0]    stat_c,
    input  logic [DW-1:0]    wregs [REG_CNT],
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        case (idx)
            4'd0:  rdata = {5'b0, tx_empty, 1'b0, rx_avail};
            4'd1:  rdata = stat_a;
            4'd2:  rdata = wregs[2];
            4'd3:  rdata = stat_b;
            4'd8:  rdata = rx_byte;
            4'd10: rdata = stat_c;
            4'd12: rdata = wregs[12];
            4'd13: rdata = wregs[13];
            4'd15: rdata = wregs[15];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic         bus_ctrl,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic         rx_avail,
    input  logic         tx_empty,
    input  logic [7:0]   rx_byte,
    input  logic [7:0]   stat_a,
    input  logic [7:0]   stat_b,
    input  logic [7:0]   stat_c,
    output logic         reg_wr_en,
    output logic [3:0]   reg_wr_idx,
    output logic [7:0]   reg_wr_data,
    output logic         tx_load,
    output logic         rx_pop,
    output logic         ius_clr
);
    logic             ctrl_wr, ctrl_rd, any_wr, any_rd, armed;
    logic [PTR_W-1:0] ptr, tgt;
    logic [DW-1:0]    wregs [REG_CNT];
    logic [DW-1:0]    mux_data;

    always_comb begin
        ctrl_wr = bus_sel &&  bus_wr &&  bus_ctrl;
        ctrl_rd = bus_sel && !bus_wr &&  bus_ctrl;
        any_wr  = bus_sel &&  bus_wr;
        any_rd  = bus_sel && !bus_wr;
        tgt     = bus_ctrl ? ptr : BUF_IDX;
    end

    regport_ptr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
        .wdata(bus_wdata), .ptr(ptr), .armed(armed)
    );

    regport_wbank u_bank (
        .clk(clk), .rst_n(rst_n), .we(any_wr), .idx(tgt),
        .wdata(bus_wdata), .regs(wregs)
    );

    regport_rmux u_mux (
        .idx(tgt), .rx_avail(rx_avail), .tx_empty(tx_empty), .rx_byte(rx_byte),
        .stat_a(stat_a), .stat_b(stat_b), .stat_c(stat_c),
        .wregs(wregs), .rdata(mux_data)
    );

    assign bus_rdata = any_rd ? mux_data : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr_en   <= 1'b0;
            reg_wr_idx  <= '0;
            reg_wr_data <= '0;
            tx_load     <= 1'b0;
            rx_pop      <= 1'b0;
            ius_clr     <= 1'b0;
        end else begin
            reg_wr_en   <= any_wr;
            reg_wr_idx  <= tgt;
            reg_wr_data <= bus_wdata;
            tx_load     <= any_wr && (tgt == BUF_IDX);
            rx_pop      <= any_rd && (tgt == BUF_IDX);
            ius_clr     <= ctrl_wr && !armed && (bus_wdata == IUS_CMD);
        end
    end

    p_txload_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (reg_wr_en && reg_wr_idx == BUF_IDX));
    p_data_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ctrl) |=> $stable(ptr));
    p_ius_reg0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ius_clr |-> (reg_wr_en && reg_wr_idx == '0 && reg_wr_data == IUS_CMD));
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_pop && reg_wr_en));
endmodule

// File: tb/sim_regport_top.sv
module sim_regport_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_ctrl = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic rx_avail = 1, tx_empty = 0;
    logic [7:0] rx_byte = 8'hA5, stat_a = 8'h11, stat_b = 8'h33, stat_c = 8'h77;
    logic reg_wr_en, tx_load, rx_pop, ius_clr;
    logic [3:0] reg_wr_idx;
    logic [7:0] reg_wr_data;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    regport_top u0 (.*);

    // {wr, ctrl, wdata, check, expected}
    localparam int NV = 25;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0,1'b1,8'h00,1'b1,8'h01},  // R6 RR0
        {1'b1,1'b1,8'h02,1'b0,8'h00},  // R2 ptr 2
        {1'b1,1'b1,8'h5C,1'b0,8'h00},  // R3 WR2
        {1'b1,1'b1,8'h02,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h5C},  // R11 RR2
        {1'b0,1'b1,8'h00,1'b1,8'h01},  // R5 back to RR0
        {1'b1,1'b1,8'h01,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h11},  // R4 RR1
        {1'b1,1'b1,8'h03,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h33},  // R11 RR3
        {1'b1,1'b1,8'h0A,1'b0,8'h00},  // R2 high flag
        {1'b0,1'b1,8'h00,1'b1,8'h77},  // R11 RR10
        {1'b1,1'b1,8'h0C,1'b0,8'h00},
        {1'b1,1'b1,8'h9E,1'b0,8'h00},
        {1'b1,1'b1,8'h0C,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h9E},  // R11 RR12
        {1'b1,1'b1,8'h04,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h00},  // R10 RR4
        {1'b1,1'b1,8'h0E,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h00},  // R10 RR14
        {1'b0,1'b0,8'h00,1'b1,8'hA5},  // R8 data read
        {1'b1,1'b1,8'h0F,1'b0,8'h00},
        {1'b1,1'b1,8'h42,1'b0,8'h00},
        {1'b1,1'b1,8'h0F,1'b0,8'h00},
        {1'b0,1'b1,8'h00,1'b1,8'h42}   // R11 RR15
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one access; returns read data seen during the strobe
    task automatic access(input logic wr, input logic ctrl, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1; bus_wr = wr; bus_ctrl = ctrl; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0; bus_ctrl = 0; bus_wdata = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 pulses", {reg_wr_en, tx_load, rx_pop, ius_clr}, 0);
        rst_n = 1;
        access(1'b0, 1'b1, 8'h00, rd);
        check("R1 idle RR0", rd, 8'h01);
        access(1'b1, 1'b1, 8'h0C, rd);
        access(1'b0, 1'b1, 8'h00, rd);
        check("R1 WR12 cleared", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][18], VEC[i][17], VEC[i][16:9], rd);
            if (VEC[i][8]) check($sformatf("vec%0d", i), rd, VEC[i][7:0]);
        end

        // R2 / R3: pointer decode and write pulse
        access(1'b1, 1'b1, 8'h0D, rd);
        check("R2 reg0 pulse idx", {reg_wr_en, reg_wr_idx}, {1'b1, 4'd0});
        // R7: data write between the two steps
        access(1'b1, 1'b0, 8'h66, rd);
        check("R7 tx_load", {tx_load, reg_wr_en, reg_wr_idx, reg_wr_data}, {1'b1, 1'b1, 4'd8, 8'h66});
        access(1'b1, 1'b1, 8'h21, rd);
        check("R3 write pulse", {reg_wr_en, reg_wr_idx, reg_wr_data, tx_load}, {1'b1, 4'd13, 8'h21, 1'b0});
        access(1'b1, 1'b1, 8'h0D, rd);
        access(1'b0, 1'b1, 8'h00, rd);
        check("R7 pointer kept R11 RR13", rd, 8'h21);

        // R8: control read of register 8
        access(1'b1, 1'b1, 8'h08, rd);
        access(1'b0, 1'b1, 8'h00, rd);
        check("R8 rdata", rd, 8'hA5);
        check("R8 rx_pop", rx_pop, 1);

        // R9: interrupt-under-service reset command
        access(1'b1, 1'b1, 8'h38, rd);
        check("R9 ius_clr", ius_clr, 1);
        tx_empty = 1; rx_avail = 0;
        access(1'b0, 1'b1, 8'h00, rd);
        check("R9 ptr zero R6 RR0", rd, 8'h04);
        check("R9 single pulse", ius_clr, 0);

        // R5: write in ARMED then read returns RR0
        access(1'b1, 1'b1, 8'h0F, rd);
        access(1'b1, 1'b1, 8'h55, rd);
        access(1'b0, 1'b1, 8'h00, rd);
        check("R5 RR0 after write", rd, 8'h04);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule